// File: doc/BRIEF.md
# Banked Working-Register and Bit-Addressable Data RAM

This block holds 128 bytes of on-chip data storage and offers three ways into it at once. A byte port reads and writes any location by its 7-bit address. A register port reaches eight working registers (numbers 0 to 7) inside whichever of four banks is currently selected. The four banks sit in the lowest 32 bytes. A bit port reads, sets or clears one of 128 single bits that live in the sixteen bytes starting at 20H.

All three ports read combinationally and commit their writes on the rising clock edge. A bit write performs its read-modify-write inside that same edge, so the other seven bits of the affected byte are left alone. The bank selection is a small register inside the block. Reset clears the bank selection to bank 0. Reset never touches the stored bytes.

When several ports write the same byte in one cycle, the byte port wins, then the register port, then the bit port. Writes to different bytes in the same cycle all take effect.

Top module: `banked_iram`

## Requirements
- R1: A byte-port write of value D to address A (0 to 7FH) makes `byte_rdata` equal D from the next cycle on whenever `byte_addr` is A.
- R2: Register number n (0 to 7) with bank b selected refers to byte address b×8 + n. This holds for both reading and writing. Bytes of banks that are not selected stay reachable through the byte port.
- R3: While reset is asserted, `bank_q` reads 0. When `bank_we` is high out of reset, `bank_q` takes `bank_wdata` at the next edge.
- R4: Bit address k (0 to 7FH) refers to bit position k[2:0] of byte 20H + k[6:3]. `bit_rdata` shows that bit combinationally.
- R5: A bit-port write sets the target bit to `bit_wval` at the next edge. The other seven bits of that byte keep their values.
- R6: When the byte port writes the same byte as the register port or the bit port in one cycle, the stored result is the byte-port data.
- R7: Asserting and releasing reset leaves every stored byte unchanged.
- R8: Byte, register and bit writes aimed at three different bytes in one cycle all take effect.
- R9: In a cycle that writes a byte, a read of that byte returns the old value. The new value appears only after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bank_we | input | 1 | Load the bank selection |
| bank_wdata | input | 2 | New bank number |
| bank_q | output | 2 | Current bank number |
| byte_addr | input | 7 | Byte port address, read and write |
| byte_we | input | 1 | Byte port write enable |
| byte_wdata | input | 8 | Byte port write data |
| byte_rdata | output | 8 | Byte port read data |
| reg_num | input | 3 | Working register number within the selected bank |
| reg_we | input | 1 | Register port write enable |
| reg_wdata | input | 8 | Register port write data |
| reg_rdata | output | 8 | Register port read data |
| bit_addr | input | 7 | Bit address into the bit region |
| bit_we | input | 1 | Bit port write enable |
| bit_wval | input | 1 | Value written to the addressed bit |
| bit_rdata | output | 1 | Addressed bit value |

## Verification
A wrong bank register sends every register-port access to another group of eight bytes. This shows at `reg_rdata` in the first read after a bank change, and at `byte_rdata` once a register write has landed in the wrong place. A fault in the bit-address mapping or the merge mask corrupts a neighbouring bit or byte. The next byte-port read of that byte exposes it, one cycle after the bit write. A broken write priority leaves the losing port's data in a contested byte. A read of that byte in the following cycle shows it. Because reads are combinational, every stored-state fault reaches the ports no later than the next read of the affected location.

// File: rtl/iram_pkg.sv
package iram_pkg;
  localparam int unsigned IRAM_DATA_W    = 8;
  localparam int unsigned IRAM_DEPTH     = 128;
  localparam int unsigned IRAM_BANKS     = 4;
  localparam int unsigned IRAM_REGS      = 8;
  localparam int unsigned IRAM_BIT_BASE  = 32;
  localparam int unsigned IRAM_BIT_BYTES = 16;

  // Which port supplies the next value of one storage row.
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_BIT  = 2'd1,
    SRC_REG  = 2'd2,
    SRC_BYTE = 2'd3
  } iram_src_e;
endpackage

// File: rtl/iram_rst_sync.sv
module iram_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/iram_addr_map.sv
module iram_addr_map #(
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned REG_W    = 3,
  parameter int unsigned BITA_W   = 7,
  parameter int unsigned POS_W    = 3,
  parameter int unsigned BIT_BASE = 32
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [REG_W-1:0]  reg_num,
  input  logic [BITA_W-1:0] bit_addr,
  output logic [ADDR_W-1:0] reg_byte,
  output logic [ADDR_W-1:0] bit_byte,
  output logic [POS_W-1:0]  bit_pos
);
  localparam int unsigned ROW_W = BITA_W - POS_W;

  logic [ROW_W-1:0] bit_row;

  always_comb begin
    reg_byte = ADDR_W'({bank, reg_num});
    bit_row  = bit_addr[BITA_W-1:POS_W];
    bit_byte = ADDR_W'(BIT_BASE) + ADDR_W'(bit_row);
    bit_pos  = bit_addr[POS_W-1:0];
  end
endmodule

// File: rtl/iram_bit_merge.sv
module iram_bit_merge #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned POS_W  = 3
) (
  input  logic [DATA_W-1:0] old_byte,
  input  logic [POS_W-1:0]  pos,
  input  logic              val,
  output logic [DATA_W-1:0] new_byte,
  output logic              old_bit
);
  always_comb begin
    new_byte = old_byte;
    old_bit  = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (pos == POS_W'(i)) begin
        new_byte[i] = val;
        old_bit     = old_byte[i];
      end
    end
  end
endmodule

// File: rtl/iram_store.sv
module iram_store
  import iram_pkg::*;
#(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              byte_we,
  input  logic [ADDR_W-1:0] byte_waddr,
  input  logic [DATA_W-1:0] byte_wdata,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_waddr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              bit_we,
  input  logic [ADDR_W-1:0] bit_waddr,
  input  logic [DATA_W-1:0] bit_wdata,
  input  logic [ADDR_W-1:0] rd_addr_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  input  logic [ADDR_W-1:0] rd_addr_c,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b,
  output logic [DATA_W-1:0] rd_data_c
);
  logic [DATA_W-1:0] mem   [DEPTH];
  logic [DATA_W-1:0] row_d [DEPTH];
  logic [DEPTH-1:0]  row_en;

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    iram_src_e src;
    always_comb begin
      if (byte_we && byte_waddr == ADDR_W'(g))     src = SRC_BYTE;
      else if (reg_we && reg_waddr == ADDR_W'(g))  src = SRC_REG;
      else if (bit_we && bit_waddr == ADDR_W'(g))  src = SRC_BIT;
      else                                          src = SRC_HOLD;
    end
    assign row_en[g] = (src != SRC_HOLD);
    assign row_d[g]  = (src == SRC_BYTE) ? byte_wdata :
                       (src == SRC_REG)  ? reg_wdata  : bit_wdata;
  end

  // Storage rows carry no reset: contents survive a reset.
  always_ff @(posedge clk) begin
    for (int r = 0; r < DEPTH; r++) begin
      if (row_en[r]) mem[r] <= row_d[r];
    end
  end

  assign rd_data_a = mem[rd_addr_a];
  assign rd_data_b = mem[rd_addr_b];
  assign rd_data_c = mem[rd_addr_c];
endmodule

// File: rtl/banked_iram.sv
module banked_iram
  import iram_pkg::*;
#(
  parameter int unsigned DATA_W    = IRAM_DATA_W,
  parameter int unsigned DEPTH     = IRAM_DEPTH,
  parameter int unsigned BANKS     = IRAM_BANKS,
  parameter int unsigned REGS      = IRAM_REGS,
  parameter int unsigned BIT_BASE  = IRAM_BIT_BASE,
  parameter int unsigned BIT_BYTES = IRAM_BIT_BYTES,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned BANK_W = $clog2(BANKS),
  localparam int unsigned REG_W  = $clog2(REGS),
  localparam int unsigned POS_W  = $clog2(DATA_W),
  localparam int unsigned BITA_W = $clog2(BIT_BYTES * DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_we,
  input  logic [BANK_W-1:0] bank_wdata,
  output logic [BANK_W-1:0] bank_q,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic              byte_we,
  input  logic [DATA_W-1:0] byte_wdata,
  output logic [DATA_W-1:0] byte_rdata,
  input  logic [REG_W-1:0]  reg_num,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [BITA_W-1:0] bit_addr,
  input  logic              bit_we,
  input  logic              bit_wval,
  output logic              bit_rdata
);
  logic              rst_q;
  logic [BANK_W-1:0] bank_d;
  logic              bank_en;
  logic [ADDR_W-1:0] reg_byte;
  logic [ADDR_W-1:0] bit_byte;
  logic [POS_W-1:0]  bit_pos;
  logic [DATA_W-1:0] bit_old;
  logic [DATA_W-1:0] bit_new;

  iram_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q)
  );

  // Bank selection: next-state and register kept apart.
  always_comb begin
    bank_en = bank_we;
    bank_d  = bank_wdata;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)       bank_q <= '0;
    else if (bank_en) bank_q <= bank_d;
  end

  iram_addr_map #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .REG_W(REG_W),
    .BITA_W(BITA_W), .POS_W(POS_W), .BIT_BASE(BIT_BASE)
  ) u_map (
    .bank     (bank_q),
    .reg_num  (reg_num),
    .bit_addr (bit_addr),
    .reg_byte (reg_byte),
    .bit_byte (bit_byte),
    .bit_pos  (bit_pos)
  );

  iram_bit_merge #(.DATA_W(DATA_W), .POS_W(POS_W)) u_merge (
    .old_byte (bit_old),
    .pos      (bit_pos),
    .val      (bit_wval),
    .new_byte (bit_new),
    .old_bit  (bit_rdata)
  );

  iram_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .byte_we    (byte_we),
    .byte_waddr (byte_addr),
    .byte_wdata (byte_wdata),
    .reg_we     (reg_we),
    .reg_waddr  (reg_byte),
    .reg_wdata  (reg_wdata),
    .bit_we     (bit_we),
    .bit_waddr  (bit_byte),
    .bit_wdata  (bit_new),
    .rd_addr_a  (byte_addr),
    .rd_addr_b  (reg_byte),
    .rd_addr_c  (bit_byte),
    .rd_data_a  (byte_rdata),
    .rd_data_b  (reg_rdata),
    .rd_data_c  (bit_old)
  );
endmodule

// File: rtl/banked_iram_chk.sv
module banked_iram_chk #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned REG_W  = 3,
  parameter int unsigned BITA_W = 7,
  parameter int unsigned POS_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_q,
  input logic              bank_we,
  input logic [BANK_W-1:0] bank_wdata,
  input logic [BANK_W-1:0] bank_q,
  input logic [ADDR_W-1:0] byte_addr,
  input logic              byte_we,
  input logic [DATA_W-1:0] byte_wdata,
  input logic [DATA_W-1:0] byte_rdata,
  input logic [REG_W-1:0]  reg_num,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [BITA_W-1:0] bit_addr,
  input logic              bit_we,
  input logic              bit_wval,
  input logic              bit_rdata,
  input logic [ADDR_W-1:0] reg_byte,
  input logic [ADDR_W-1:0] bit_byte
);
  AST_BANK_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> (bank_q == '0)); // R3

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_q)
    bank_we |=> (bank_q == $past(bank_wdata))); // R3

  AST_BYTE_WRITE: assert property (@(posedge clk) disable iff (!rst_q)
    byte_we |=> (byte_addr != $past(byte_addr)) || (byte_rdata == $past(byte_wdata))); // R1

  AST_BYTE_WINS: assert property (@(posedge clk) disable iff (!rst_q)
    (byte_we && ((reg_we && byte_addr == reg_byte) || (bit_we && byte_addr == bit_byte)))
    |=> (byte_addr != $past(byte_addr)) || (byte_rdata == $past(byte_wdata))); // R6

  AST_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_q)
    (reg_we && !(byte_we && byte_addr == reg_byte))
    |=> (reg_num != $past(reg_num)) || (bank_q != $past(bank_q)) ||
        (reg_rdata == $past(reg_wdata))); // R2

  AST_BIT_WRITE: assert property (@(posedge clk) disable iff (!rst_q)
    (bit_we && !byte_we && !reg_we)
    |=> (bit_addr != $past(bit_addr)) || (bit_rdata == $past(bit_wval))); // R4

  AST_BIT_NEIGHBOURS: assert property (@(posedge clk) disable iff (!rst_q)
    (bit_we && !byte_we && !reg_we && byte_addr == bit_byte)
    |=> (byte_addr != $past(byte_addr)) ||
        (((byte_rdata ^ $past(byte_rdata)) &
          ~(DATA_W'(1) << $past(bit_addr[POS_W-1:0]))) == '0)); // R5
endmodule

bind banked_iram banked_iram_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W),
  .REG_W(REG_W), .BITA_W(BITA_W), .POS_W(POS_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_q      (rst_q),
  .bank_we    (bank_we),
  .bank_wdata (bank_wdata),
  .bank_q     (bank_q),
  .byte_addr  (byte_addr),
  .byte_we    (byte_we),
  .byte_wdata (byte_wdata),
  .byte_rdata (byte_rdata),
  .reg_num    (reg_num),
  .reg_we     (reg_we),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .bit_addr   (bit_addr),
  .bit_we     (bit_we),
  .bit_wval   (bit_wval),
  .bit_rdata  (bit_rdata),
  .reg_byte   (reg_byte),
  .bit_byte   (bit_byte)
);

// File: tb/tb_banked_iram.sv
module tb_banked_iram;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bank_we = 1'b0;
  logic [1:0] bank_wdata = '0;
  logic [1:0] bank_q;
  logic [6:0] byte_addr = '0;
  logic       byte_we = 1'b0;
  logic [7:0] byte_wdata = '0;
  logic [7:0] byte_rdata;
  logic [2:0] reg_num = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [6:0] bit_addr = '0;
  logic       bit_we = 1'b0;
  logic       bit_wval = 1'b0;
  logic       bit_rdata;

  banked_iram dut (
    .clk(clk), .rst_n(rst_n),
    .bank_we(bank_we), .bank_wdata(bank_wdata), .bank_q(bank_q),
    .byte_addr(byte_addr), .byte_we(byte_we), .byte_wdata(byte_wdata), .byte_rdata(byte_rdata),
    .reg_num(reg_num), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bit_addr(bit_addr), .bit_we(bit_we), .bit_wval(bit_wval), .bit_rdata(bit_rdata)
  );

  always #5 clk = ~clk;

  // Reference model and pending write of the previous cycle.
  logic [7:0] m [128];
  logic [1:0] bank_m = '0;
  logic       p_bwe = 1'b0, p_rwe = 1'b0, p_twe = 1'b0, p_kwe = 1'b0, p_tv = 1'b0;
  logic [6:0] p_ba = '0, p_ta = '0;
  logic [2:0] p_rn = '0;
  logic [7:0] p_bd = '0, p_rd = '0;
  logic [1:0] p_kd = '0;

  // Scoreboard queues: port id (0 byte, 1 reg, 2 bit, 3 bank), expected value, tag.
  int         q_port[$];
  logic [7:0] q_exp[$];
  string      q_tag[$];
  int         n_checks = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  task automatic chk(input int port, input logic [7:0] exp, input string tag);
    q_port.push_back(port);
    q_exp.push_back(exp);
    q_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    while (q_port.size() > 0) begin
      int         p;
      logic [7:0] e;
      logic [7:0] a;
      string      t;
      p = q_port.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      case (p)
        0: a = byte_rdata;
        1: a = reg_rdata;
        2: a = {7'd0, bit_rdata};
        default: a = {6'd0, bank_q};
      endcase
      n_checks++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s port%0d actual=%h expected=%h t=%0t", t, p, a, e, $time);
      end
    end
  end

  // Model commit at the edge: bit, then register, then byte (byte wins).
  task automatic commit();
    if (p_twe) m[7'h20 + {3'd0, p_ta[6:3]}][p_ta[2:0]] = p_tv;
    if (p_rwe) m[{2'd0, bank_m, p_rn}] = p_rd;
    if (p_bwe) m[p_ba] = p_bd;
    if (p_kwe) bank_m = p_kd;
  endtask

  task automatic step(input logic bwe, input logic [6:0] ba, input logic [7:0] bd,
                      input logic rwe, input logic [2:0] rn, input logic [7:0] rd,
                      input logic twe, input logic [6:0] ta, input logic tv,
                      input logic kwe, input logic [1:0] kd);
    @(posedge clk);
    commit();
    #1;
    byte_we = bwe; byte_addr = ba; byte_wdata = bd;
    reg_we = rwe; reg_num = rn; reg_wdata = rd;
    bit_we = twe; bit_addr = ta; bit_wval = tv;
    bank_we = kwe; bank_wdata = kd;
    p_bwe = bwe; p_ba = ba; p_bd = bd;
    p_rwe = rwe; p_rn = rn; p_rd = rd;
    p_twe = twe; p_ta = ta; p_tv = tv;
    p_kwe = kwe; p_kd = kd;
  endtask

  task automatic idle();
    step(0, byte_addr, 0, 0, reg_num, 0, 0, bit_addr, 0, 0, 0);
  endtask

  task automatic look(input logic [6:0] ba, input logic [2:0] rn, input logic [6:0] ta,
                      input string tag);
    step(0, ba, 0, 0, rn, 0, 0, ta, 0, 0, 0);
    chk(0, m[ba], tag);
    chk(1, m[{2'd0, bank_m, rn}], "R2");
    chk(2, {7'd0, m[7'h20 + {3'd0, ta[6:3]}][ta[2:0]]}, "R4");
    chk(3, {6'd0, bank_m}, "R3");
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    bank_m = '0;
    chk(3, 8'd0, "R3");
    repeat (3) idle();
    rst_n = 1'b1;
    repeat (4) idle();
  endtask

  initial begin
    // Reset state: bank 0 (R3).
    idle();
    chk(3, 8'd0, "R3");
    repeat (2) idle();
    rst_n = 1'b1;
    repeat (4) idle();

    // R1: fill and read back every byte.
    for (int a = 0; a < 128; a++)
      step(1, 7'(a), 8'(a * 29 + 7) ^ 8'h5A, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int a = 0; a < 128; a++)
      look(7'(a), 3'(a), 7'(a), "R1");

    // R2/R3: register writes in each bank, checked through the byte port.
    for (int b = 0; b < 4; b++) begin
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2'(b));
      look(0, 0, 0, "R3");
      for (int n = 0; n < 8; n++)
        step(0, 0, 0, 1, 3'(n), 8'(8'hA0 + b * 16 + n), 0, 0, 0, 0, 0);
      for (int n = 0; n < 8; n++)
        look(7'(b * 8 + n), 3'(n), 0, "R2");
    end
    // Bank 3 selected; bank 1 bytes still reachable by byte address (R2).
    look(7'h0D, 3'd5, 0, "R2");

    // R4/R5: single-bit writes keep neighbours.
    step(1, 7'h25, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 7'h25, 0, 0, 0, 0, 1, 7'h2B, 1, 0, 0);
    look(7'h25, 0, 7'h2B, "R5");
    chk(0, 8'h08, "R5");
    step(1, 7'h2F, 8'hFF, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 7'h2F, 0, 0, 0, 0, 1, 7'h7F, 0, 0, 0);
    look(7'h2F, 0, 7'h7F, "R5");
    chk(0, 8'h7F, "R5");
    step(0, 7'h20, 0, 0, 0, 0, 1, 7'h00, 1, 0, 0);
    look(7'h20, 0, 7'h00, "R4");
    for (int k = 0; k < 16; k++) begin
      step(0, 7'h20 + 7'(k), 0, 0, 0, 0, 1, 7'(k * 8 + (k % 8)), 1'(k), 0, 0);
      look(7'h20 + 7'(k), 0, 7'(k * 8 + (k % 8)), "R5");
    end

    // R6: byte port wins over bit and register ports.
    step(1, 7'h24, 8'h3C, 0, 0, 0, 1, 7'h21, 1, 0, 0);
    look(7'h24, 0, 7'h21, "R6");
    chk(0, 8'h3C, "R6");
    step(1, 7'h1A, 8'h11, 1, 3'd2, 8'h99, 0, 0, 0, 0, 0);
    look(7'h1A, 3'd2, 0, "R6");
    chk(1, 8'h11, "R6");

    // R8: three different targets in one cycle.
    step(1, 7'h40, 8'h77, 1, 3'd5, 8'h66, 1, 7'h33, 1, 0, 0);
    look(7'h40, 3'd5, 7'h33, "R8");
    look(7'h1D, 3'd5, 7'h33, "R8");
    look(7'h26, 3'd5, 7'h33, "R8");

    // R9: same-cycle read returns the old value.
    step(1, 7'h50, 8'hEE, 0, 0, 0, 0, 0, 0, 0, 0);
    chk(0, m[7'h50], "R9");
    look(7'h50, 0, 0, "R1");

    // R7: reset keeps contents, bank returns to 0.
    do_reset();
    look(7'h00, 3'd0, 7'h2B, "R7");
    look(7'h1D, 3'd3, 7'h21, "R7");
    look(7'h40, 3'd7, 7'h7F, "R7");
    look(7'h7F, 3'd1, 7'h00, "R7");

    idle();
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog (all) actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule